// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It supports eight instructions: register-register add, subtract, AND, OR and signed set-less-than, plus word load, word store and branch-if-equal. The core holds its program counter, a 32-entry register file, an ALU with a zero flag, the immediate sign extender, the branch-target adder, the operand and write-back selectors, and the instruction decode. Instruction and data memory are small internal word arrays.

A debug port lets the environment preload either memory while the core is held in reset. The same port reads back instruction memory, data memory or any register without disturbing execution. Address bits [1:0] are ignored on every memory access. Indices wrap modulo the memory depth. A program normally ends on a branch to itself.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears every register on the clock edge where it is sampled high. While `rst` is high, no instruction writes a register or the data memory.
- R2: The PC is always word aligned. Every instruction that is not a taken branch advances the PC by exactly 4.
- R3: Opcode 0x00 is the register-register format, with fields rs=[25:21], rt=[20:16] and rd=[15:11]. Funct [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The result is written to rd and never to rt.
- R4: Register 0 always reads as zero, and a write aimed at it leaves it at zero.
- R5: Opcode 0x23 (load) writes rt with the data word at index ((rs + sign-extended imm[15:0]) >> 2). The offset may be negative.
- R6: Opcode 0x2B (store) writes rt to the data word at index ((rs + sign-extended imm) >> 2) and writes no register.
- R7: Opcode 0x04 (branch-if-equal) sets the PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. A branch writes neither a register nor memory.
- R8: A register written by one instruction holds the new value for the instruction on the next cycle.
- R9: Any other opcode writes neither a register nor memory, and the PC advances by 4.
- R10: Debug port: when `dbg_we` is high, `dbg_wdata` is written on the clock edge into instruction memory (`dbg_sel`=0) or data memory (`dbg_sel`=1). `dbg_rdata` combinationally shows instruction memory (0), data memory (1) or register `dbg_addr[4:0]` (2), at word `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Debug write strobe |
| dbg_sel | input | 2 | Debug target: 0 instruction memory, 1 data memory, 2 register file |
| dbg_addr | input | DBG_AW | Debug word index or register number |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, combinational |
| pc_o | output | 32 | Current program counter |

## Verification
Every instruction takes effect on the single rising edge that executes it. The PC after the k-th edge following reset release is predicted in the bench from the program. It is compared half a period after that edge, at the falling edge, so the bench never samples while the registers update. Register and memory results from a whole program are read through the combinational debug port once the program is parked on its self-branch. No later instruction can change them by then, so the comparison is independent of the cycle on which each result first appeared. The ALU sweep runs every operation over all ordered pairs of six corner operands, and each expected value is computed arithmetically in the bench.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_WORDS = 256,
  parameter int DBG_AW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_we,
  input  logic [1:0]        dbg_sel,
  input  logic [DBG_AW-1:0] dbg_addr,
  input  logic [31:0]       dbg_wdata,
  output logic [31:0]       dbg_rdata,
  output logic [31:0]       pc_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;

  localparam logic [2:0] A_ADD = 3'd0, A_SUB = 3'd1, A_AND = 3'd2, A_OR = 3'd3, A_SLT = 3'd4, A_NIL = 3'd5;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc;

  logic [31:0] instr;
  logic [5:0]  opc, fn;
  logic [4:0]  rs, rt, rd, wa;
  logic [31:0] imm_x, opa, opb, rd_b, alu_y, ld_data, wd;
  logic [31:0] pc_inc, br_target, pc_next;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, zero, take_br;
  logic [1:0]  alu_op;
  logic [2:0]  alu_fn;

  assign instr = imem[pc[IAW+1:2]];
  assign opc   = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign fn    = instr[5:0];
  assign imm_x = {{16{instr[15]}}, instr[15:0]};

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    alu_op     = 2'b00;
    case (opc)
      OP_RR:   begin reg_dst = 1'b1; reg_write = 1'b1; alu_op = 2'b10; end
      OP_LOAD: begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; end
      OP_STOR: begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ:  begin branch = 1'b1; alu_op = 2'b01; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (alu_op)
      2'b00: alu_fn = A_ADD;
      2'b01: alu_fn = A_SUB;
      default:
        case (fn)
          6'h20:   alu_fn = A_ADD;
          6'h22:   alu_fn = A_SUB;
          6'h24:   alu_fn = A_AND;
          6'h25:   alu_fn = A_OR;
          6'h2A:   alu_fn = A_SLT;
          default: alu_fn = A_NIL;
        endcase
    endcase
  end

  assign opa  = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rd_b = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign opb  = alu_src ? imm_x : rd_b;

  always_comb begin
    case (alu_fn)
      A_ADD:   alu_y = opa + opb;
      A_SUB:   alu_y = opa - opb;
      A_AND:   alu_y = opa & opb;
      A_OR:    alu_y = opa | opb;
      A_SLT:   alu_y = {31'd0, $signed(opa) < $signed(opb)};
      default: alu_y = 32'd0;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign ld_data = dmem[alu_y[DAW+1:2]];
  assign wa      = reg_dst ? rd : rt;
  assign wd      = mem_to_reg ? ld_data : alu_y;

  assign pc_inc    = pc + 32'd4;
  assign br_target = pc_inc + {imm_x[29:0], 2'b00};
  assign take_br   = branch & zero;
  assign pc_next   = take_br ? br_target : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (reg_write && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (dbg_we && dbg_sel == 2'd0) imem[dbg_addr[IAW-1:0]] <= dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (dbg_we && dbg_sel == 2'd1) dmem[dbg_addr[DAW-1:0]] <= dbg_wdata;
    else if (!rst && mem_write)    dmem[alu_y[DAW+1:2]]   <= rd_b;
  end

  always_comb begin
    case (dbg_sel)
      2'd0:    dbg_rdata = imem[dbg_addr[IAW-1:0]];
      2'd1:    dbg_rdata = dmem[dbg_addr[DAW-1:0]];
      2'd2:    dbg_rdata = rf[dbg_addr[4:0]];
      default: dbg_rdata = 32'd0;
    endcase
  end

  assign pc_o = pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        take,
  input logic [31:0] target,
  input logic [31:0] r0,
  input logic        mem_write,
  input logic        reg_write,
  input logic        branch
);
  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == 32'd0); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) !take |=> pc == $past(pc) + 32'd4); // R2
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst) take |=> pc == $past(target)); // R7
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst) r0 == 32'd0); // R4
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst) branch |-> !(mem_write || reg_write)); // R7
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_o), .take(take_br), .target(br_target),
  .r0(rf[0]), .mem_write(mem_write), .reg_write(reg_write), .branch(branch)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_we = 1'b0;
  logic [1:0]  dbg_sel = 2'd0;
  logic [15:0] dbg_addr = 16'd0;
  logic [31:0] dbg_wdata = 32'd0;
  logic [31:0] dbg_rdata, pc_o;

  always #5 clk = ~clk;

  sc_core uut (.clk(clk), .rst(rst), .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_addr(dbg_addr),
               .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .pc_o(pc_o));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  function automatic logic [31:0] alu_ref(input logic [31:0] a, input logic [31:0] b, input int op);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic dwr(input logic [1:0] sel, input int addr, input logic [31:0] data);
    dbg_we = 1'b1; dbg_sel = sel; dbg_addr = 16'(addr); dbg_wdata = data;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic drd(input logic [1:0] sel, input int addr, output logic [31:0] data);
    dbg_sel = sel; dbg_addr = 16'(addr);
    #1 data = dbg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  logic [31:0] v [6];
  logic [5:0]  fcode [5];
  int exp_pc2 [14];

  initial begin
    logic [31:0] d;
    int p, idx;
    v[0] = 32'd0; v[1] = 32'd1; v[2] = 32'hFFFFFFFF;
    v[3] = 32'h7FFFFFFF; v[4] = 32'h80000000; v[5] = 32'h12345678;
    fcode[0] = 6'h20; fcode[1] = 6'h22; fcode[2] = 6'h24; fcode[3] = 6'h25; fcode[4] = 6'h2A;

    @(negedge clk);
    // Program 1: load six corner operands, sweep all ops and pairs, store each result
    for (int i = 0; i < 6; i++) dwr(2'd1, i, v[i]);
    p = 0;
    for (int i = 1; i <= 6; i++) begin dwr(2'd0, p, enc_i(6'h23, 0, i, (i - 1) * 4)); p++; end
    idx = 0;
    for (int a = 1; a <= 6; a++)
      for (int b = 1; b <= 6; b++)
        for (int op = 0; op < 5; op++) begin
          dwr(2'd0, p, enc_r(a, b, 7, fcode[op])); p++;
          dwr(2'd0, p, enc_i(6'h2B, 0, 7, (16 + idx) * 4)); p++;
          idx++;
        end
    dwr(2'd0, p, enc_i(6'h04, 0, 0, -1));

    drd(2'd0, 0, d); chk("R10 imem debug readback", d, enc_i(6'h23, 0, 1, 0));
    drd(2'd1, 5, d); chk("R10 dmem debug readback", d, v[5]);
    chk("R1 pc in reset", pc_o, 32'd0);
    drd(2'd2, 6, d); chk("R1 register cleared", d, 32'd0);

    rst = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R2 pc step", pc_o, 32'(4 * k));
    end
    repeat (p + 4) @(negedge clk);
    chk("R7 self-branch holds pc", pc_o, 32'(4 * p));

    idx = 0;
    for (int a = 1; a <= 6; a++)
      for (int b = 1; b <= 6; b++)
        for (int op = 0; op < 5; op++) begin
          drd(2'd1, 16 + idx, d);
          chk("R3/R8 alu sweep result", d, alu_ref(v[a - 1], v[b - 1], op));
          idx++;
        end
    for (int i = 1; i <= 6; i++) begin
      drd(2'd2, i, d); chk("R5 loaded operand", d, v[i - 1]);
    end
    drd(2'd2, 7, d); chk("R3 last result in rd", d, alu_ref(v[5], v[5], 4));

    // Program 2: branches, register 0, negative offsets, rd vs rt, unknown opcode
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'd0);
    drd(2'd2, 7, d); chk("R1 register cleared by reset", d, 32'd0);
    dwr(2'd1, 100, 32'd400);
    dwr(2'd1, 50, 32'hDEAD0050);
    dwr(2'd1, 51, 32'hDEAD0051);
    dwr(2'd1, 98, 32'h0);
    dwr(2'd0, 0,  enc_i(6'h23, 0, 1, 4));
    dwr(2'd0, 1,  enc_i(6'h23, 0, 2, 8));
    dwr(2'd0, 2,  enc_r(1, 1, 0, 6'h20));
    dwr(2'd0, 3,  enc_i(6'h04, 1, 2, 5));
    dwr(2'd0, 4,  enc_i(6'h04, 1, 1, 2));
    dwr(2'd0, 5,  enc_i(6'h2B, 0, 1, 200));
    dwr(2'd0, 6,  enc_i(6'h2B, 0, 1, 204));
    dwr(2'd0, 7,  enc_r(0, 2, 3, 6'h20));
    dwr(2'd0, 8,  enc_i(6'h23, 0, 5, 400));
    dwr(2'd0, 9,  enc_i(6'h2B, 5, 3, -8));
    dwr(2'd0, 10, enc_i(6'h23, 5, 6, -8));
    dwr(2'd0, 11, enc_r(1, 1, 7, 6'h20));
    dwr(2'd0, 12, enc_i(6'h3F, 0, 1, 4));
    dwr(2'd0, 13, enc_i(6'h04, 0, 0, -1));
    exp_pc2 = '{4, 8, 12, 16, 28, 32, 36, 40, 44, 48, 52, 52, 52, 52};

    rst = 1'b0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      chk("R7/R2 pc trace", pc_o, 32'(exp_pc2[k]));
    end
    drd(2'd2, 0, d); chk("R4 r0 write ignored", d, 32'd0);
    drd(2'd2, 1, d); chk("R9 unknown opcode left rt unchanged", d, 32'd1);
    drd(2'd2, 2, d); chk("R5 load", d, 32'hFFFFFFFF);
    drd(2'd2, 3, d); chk("R4 r0 reads zero as operand", d, 32'hFFFFFFFF);
    drd(2'd2, 5, d); chk("R5 load base value", d, 32'd400);
    drd(2'd2, 6, d); chk("R5 load negative offset into rt", d, 32'hFFFFFFFF);
    drd(2'd2, 7, d); chk("R3 result to rd", d, 32'd2);
    drd(2'd1, 98, d); chk("R6 store negative offset", d, 32'hFFFFFFFF);
    drd(2'd1, 50, d); chk("R7 skipped store 0", d, 32'hDEAD0050);
    drd(2'd1, 51, d); chk("R7 skipped store 1", d, 32'hDEAD0051);
    drd(2'd1, 1, d); chk("R9 unknown opcode no memory write", d, 32'd1);
    drd(2'd2, 4, d); chk("R6 store writes no register", d, 32'd0);

    summary();
    $finish;
  end
endmodule